// File: doc/BRIEF.md
# Chained Control Register Bus

This block lets one requester reach a set of small control registers spread over several register nodes. A single bus master takes a request (read or write, a 10-bit register address, 32 bits of write data). It drives the address and one strobe onto a shared bus. It then waits for an acknowledge to come back. Each register node owns a short, contiguous window of addresses and holds a bank of registers. A node can store 32, 16 or 8 bits per register.

Read data does not pass through one wide central selector. The nodes form a chain. A node that is not addressed passes the incoming read data and acknowledge straight on. The addressed node puts its own register value on the chain and raises the acknowledge. The master keeps the address and strobe steady until the acknowledge arrives. It then drops the strobe and waits for the acknowledge to fall before it accepts the next request. An access to an address that no node owns ends after a fixed wait, with a zero read value and a timeout flag.

The register contents are brought out, zero-extended to 32 bits, so the logic around the block can use them.

Top module: `regchain_bus`

## Requirements
- R1: While reset is asserted and directly after it, `req_ready` is 1, `resp_done` and `resp_timeout` are 0, and every register on `reg_q` reads 0.
- R2: With default parameters, node i (i = 0, 1, 2) owns addresses 0x040+4i to 0x043+4i. Register k of node i sits at `reg_q[(4i+k)*32 +: 32]`. A write changes only the addressed register, and the new value is visible on `reg_q` after the first rising edge following acceptance.
- R3: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. For an owned address, `resp_done` is 1 for exactly one cycle, after the second rising edge following acceptance. For a read, `resp_rdata` then holds the register value.
- R4: Node i stores 32 bits when i mod 3 is 0, 16 bits when it is 1, and 8 bits when it is 2. Write data above that width is dropped, and those bits read as 0 on `resp_rdata` and `reg_q`.
- R5: Every access holds the strobe for at least two cycles, with the address stable while it is held. `resp_done` never rises sooner than three falling edges after the request was driven.
- R6: An access to an address that no node owns completes after the 32nd rising edge following acceptance. It completes with `resp_done`=1, `resp_timeout`=1 and `resp_rdata`=0, and no register changes.
- R7: `req_ready` is 0 from acceptance until the acknowledge has fallen. For an owned address it returns after the 4th rising edge; for an unowned one, after the 33rd. While `req_ready` is 0, `req_valid` is ignored.
- R8: A read returns the value of the owning node wherever that node sits in the chain, with every other node passing the data on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Register address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Master idle, can accept a request |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_timeout | output | 1 | Completion was by timeout (no owner) |
| resp_rdata | output | 32 | Read data, valid with `resp_done` |
| reg_q | output | 384 | All register contents, zero-extended, node-major |

## Verification
One cycle can carry two events at once: the end of one access, where the acknowledge is still high, and the next request, with `req_valid` already high. The bench provokes this by holding `req_valid` high across many back-to-back accesses. A behavioural model judges every cycle, checking that only one request is taken per completed handshake and that `req_ready` returns exactly four or thirty-three edges after acceptance. A second overlap is a write and the read of the same register in the same node cycle. The model expects the old value on the write's own response, and the new value only on `reg_q` and later reads.

// File: rtl/regchain_pkg.sv
package regchain_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    M_IDLE    = 2'd0,
    M_ACCESS  = 2'd1,
    M_RELEASE = 2'd2
  } mst_state_e;

  // storage width of node i: 32, 16, 8 repeating
  function automatic int node_width(input int i);
    case (i % 3)
      0:       return 32;
      1:       return 16;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/regchain_master.sv
module regchain_master
  import regchain_pkg::*;
#(
  parameter int TIMEOUT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_done,
  output logic              resp_timeout,
  output logic [DATA_W-1:0] resp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_wr,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int CNT_W = $clog2(TIMEOUT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  mst_state_e        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              rd_q, rd_n, wr_q, wr_n;
  logic              done_q, done_n, tout_q, tout_n;
  logic [DATA_W-1:0] rdata_q, rdata_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              lat_en, rdata_en;

  assign lat_en = (state_q == M_IDLE) && req_valid;

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    rd_n     = rd_q;
    wr_n     = wr_q;
    done_n   = 1'b0;
    tout_n   = 1'b0;
    rdata_n  = rdata_q;
    rdata_en = 1'b0;
    case (state_q)
      M_IDLE: begin
        if (req_valid) begin
          rd_n    = !req_write;
          wr_n    = req_write;
          cnt_n   = '0;
          state_n = M_ACCESS;
        end
      end
      M_ACCESS: begin
        if (bus_ack) begin
          rd_n     = 1'b0;
          wr_n     = 1'b0;
          done_n   = 1'b1;
          rdata_n  = bus_rdata;
          rdata_en = 1'b1;
          state_n  = M_RELEASE;
        end else if (cnt_q == LAST) begin
          rd_n     = 1'b0;
          wr_n     = 1'b0;
          done_n   = 1'b1;
          tout_n   = 1'b1;
          rdata_n  = '0;
          rdata_en = 1'b1;
          state_n  = M_RELEASE;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: begin
        if (!bus_ack) state_n = M_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      rd_q    <= rd_n;
      wr_q    <= wr_n;
      done_q  <= done_n;
      tout_q  <= tout_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (lat_en) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rdata_en) rdata_q <= rdata_n;
    end
  end

  assign req_ready    = (state_q == M_IDLE);
  assign resp_done    = done_q;
  assign resp_timeout = tout_q;
  assign resp_rdata   = rdata_q;
  assign bus_addr     = addr_q;
  assign bus_wdata    = wdata_q;
  assign bus_rd       = rd_q;
  assign bus_wr       = wr_q;
endmodule

// File: rtl/regchain_node.sv
module regchain_node
  import regchain_pkg::*;
#(
  parameter int BASE  = 64,
  parameter int REGS  = 4,
  parameter int REG_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic                   ack_in,
  input  logic [DATA_W-1:0]      rdata_in,
  output logic                   ack_out,
  output logic [DATA_W-1:0]      rdata_out,
  output logic [REGS*DATA_W-1:0] regs_out
);
  localparam int IDX_W = (REGS > 1) ? $clog2(REGS) : 1;
  localparam logic [ADDR_W-1:0] LO   = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] NREG = ADDR_W'(REGS);
  localparam logic [DATA_W-1:0] MASK = (REG_W >= DATA_W) ? '1 : DATA_W'((64'd1 << REG_W) - 64'd1);

  logic [ADDR_W-1:0] off;
  logic              hit, stb, first, ack_q;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rd_q, rd_n;
  logic [DATA_W-1:0] mem [REGS];

  assign off   = bus_addr - LO;
  assign hit   = (bus_addr >= LO) && (off < NREG);
  assign idx   = IDX_W'(off);
  assign stb   = bus_rd || bus_wr;
  assign first = stb && hit && !ack_q;

  always_comb begin
    rd_n = mem[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      ack_q <= stb && hit;
      if (first) rd_q <= rd_n;
    end
  end

  for (genvar k = 0; k < REGS; k++) begin : g_reg
    logic wen;
    assign wen = first && bus_wr && (idx == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[k] <= '0;
      else if (wen) mem[k] <= bus_wdata & MASK;
    end
    assign regs_out[k*DATA_W +: DATA_W] = mem[k];
  end

  // distributed read selector stage
  assign ack_out   = ack_in || ack_q;
  assign rdata_out = ack_q ? rd_q : rdata_in;
endmodule

// File: rtl/regchain_bus.sv
module regchain_bus
  import regchain_pkg::*;
#(
  parameter int NODES     = 3,
  parameter int REGS      = 4,
  parameter int BASE_ADDR = 64,
  parameter int TIMEOUT   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         req_ready,
  output logic                         resp_done,
  output logic                         resp_timeout,
  output logic [DATA_W-1:0]            resp_rdata,
  output logic [NODES*REGS*DATA_W-1:0] reg_q
);
  logic              rst_m, rst_s;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic              bus_rd, bus_wr;
  logic              ack_c  [NODES+1];
  logic [DATA_W-1:0] data_c [NODES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  regchain_master #(.TIMEOUT(TIMEOUT)) u_master (
    .clk(clk), .rst_n(rst_s),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .resp_done(resp_done),
    .resp_timeout(resp_timeout), .resp_rdata(resp_rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_ack(ack_c[NODES]), .bus_rdata(data_c[NODES])
  );

  assign ack_c[0]  = 1'b0;
  assign data_c[0] = '0;

  for (genvar i = 0; i < NODES; i++) begin : g_node
    regchain_node #(
      .BASE(BASE_ADDR + i*REGS), .REGS(REGS), .REG_W(node_width(i))
    ) u_node (
      .clk(clk), .rst_n(rst_s),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_wr(bus_wr),
      .ack_in(ack_c[i]), .rdata_in(data_c[i]),
      .ack_out(ack_c[i+1]), .rdata_out(data_c[i+1]),
      .regs_out(reg_q[i*REGS*DATA_W +: REGS*DATA_W])
    );
  end
endmodule

// File: rtl/regchain_checker.sv
module regchain_checker
  import regchain_pkg::*;
(
  input logic              clk,
  input logic              rst_s,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              resp_done,
  input logic              resp_timeout,
  input logic [DATA_W-1:0] resp_rdata
);
  logic stb;
  assign stb = bus_rd || bus_wr;

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_s)
    !(bus_rd && bus_wr));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (stb && $past(stb)) |-> $stable(bus_addr));

  p_min_two_r5: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(resp_done) |-> ($past(stb) && $past(stb, 2)));

  p_ack_after_stb_r3: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(bus_ack) |-> $past(stb));

  p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (!stb && $past(!stb)) |-> !bus_ack);

  p_timeout_zero_r6: assert property (@(posedge clk) disable iff (!rst_s)
    resp_timeout |-> (resp_done && resp_rdata == '0));
endmodule

bind regchain_bus regchain_checker u_chk (
  .clk(clk), .rst_s(rst_s),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ack(ack_c[NODES]),
  .bus_addr(bus_addr), .resp_done(resp_done),
  .resp_timeout(resp_timeout), .resp_rdata(resp_rdata)
);

// File: tb/regchain_bus_test.sv
module regchain_bus_test;
  localparam int NREGS = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_write;
  logic [9:0]   req_addr;
  logic [31:0]  req_wdata;
  logic         req_ready, resp_done, resp_timeout;
  logic [31:0]  resp_rdata;
  logic [383:0] reg_q;

  int checks = 0;
  int errors = 0;

  regchain_bus uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_done(resp_done), .resp_timeout(resp_timeout),
    .resp_rdata(resp_rdata), .reg_q(reg_q)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  logic [31:0] m_regs [NREGS];
  int          m_phase, m_t, m_idx;
  logic        m_hit, m_wr, m_done, m_tout;
  logic [9:0]  m_addr;
  logic [31:0] m_wdata, m_rd;

  function automatic logic [31:0] wmask(input int idx);
    case ((idx / 4) % 3)
      0:       return 32'hFFFF_FFFF;
      1:       return 32'h0000_FFFF;
      default: return 32'h0000_00FF;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_t = 0; m_done = 0; m_tout = 0; m_rd = 0;
      for (int k = 0; k < NREGS; k++) m_regs[k] = 0;
    end else begin
      m_done = 0; m_tout = 0;
      if (m_phase == 0) begin
        if (req_valid) begin
          m_addr = req_addr; m_wr = req_write; m_wdata = req_wdata;
          m_hit  = (req_addr >= 10'd64) && (req_addr < 10'd76);
          m_idx  = int'(req_addr) - 64;
          m_t = 0; m_phase = 1;
        end
      end else begin
        m_t++;
        if (m_hit) begin
          if (m_t == 1) begin
            m_rd = m_regs[m_idx];
            if (m_wr) m_regs[m_idx] = m_wdata & wmask(m_idx);
          end
          if (m_t == 2) m_done = 1;
          if (m_t == 4) m_phase = 0;
        end else begin
          if (m_t == 32) begin m_done = 1; m_tout = 1; m_rd = 0; end
          if (m_t == 33) m_phase = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [383:0] act, input logic [383:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [383:0] exp_q;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < NREGS; k++) exp_q[k*32 +: 32] = m_regs[k];
      check(req_ready === (m_phase == 0), "R7 ready", 384'(req_ready), 384'(m_phase == 0));
      check(resp_done === m_done, m_hit ? "R3 done" : "R6 done", 384'(resp_done), 384'(m_done));
      check(reg_q === exp_q, "R2 reg_q", reg_q, exp_q);
      if (m_done) begin
        check(resp_timeout === m_tout, "R6 timeout", 384'(resp_timeout), 384'(m_tout));
        if (!m_wr)
          check(resp_rdata === m_rd,
                !m_hit ? "R6 rdata" : (wmask(m_idx) != 32'hFFFF_FFFF ? "R4 rdata" : "R8 rdata"),
                384'(resp_rdata), 384'(m_rd));
      end
    end
  end

  task automatic access(input bit wr, input logic [9:0] a, input logic [31:0] d);
    int lat;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!resp_done && lat < 60) begin @(negedge clk); lat++; end
    check(lat >= 3, "R5 latency", 384'(lat), 384'(3));
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    check(req_ready === 1 && resp_done === 0 && resp_timeout === 0 && reg_q === '0,
          "R1 reset", reg_q, '0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(req_ready === 1 && reg_q === '0, "R1 after reset", reg_q, '0);

    // R2 R8: fill every register, then read all back
    for (int k = 0; k < NREGS; k++) access(1, 10'(64 + k), 32'hC0DE_0000 + 32'(k * 32'h1111));
    for (int k = NREGS - 1; k >= 0; k--) access(0, 10'(64 + k), 0);
    // R4: all-ones into every register
    for (int k = 0; k < NREGS; k++) access(1, 10'(64 + k), 32'hFFFF_FFFF);
    for (int k = 0; k < NREGS; k++) access(0, 10'(64 + k), 0);
    // R6: unowned addresses
    access(0, 10'h000, 0);
    access(1, 10'h04C, 32'h1234_5678);
    access(0, 10'h3FF, 0);
    access(0, 10'h03F, 0);
    // R7: requester holds valid across back-to-back accesses
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 10'h045; req_wdata = 32'hABCD_9876;
    repeat (6) @(negedge clk);
    req_write = 0; req_addr = 10'h049;
    repeat (10) @(negedge clk);
    req_addr = 10'h050;
    repeat (40) @(negedge clk);
    req_valid = 0;
    repeat (40) @(negedge clk);
    access(0, 10'h045, 0);
    access(1, 10'h040, 32'h0BAD_F00D);
    access(0, 10'h040, 0);
    repeat (6) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule